// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes four shared PCI interrupt request inputs and steers each one onto one of sixteen legacy interrupt lines. The sixteen lines feed a pair of cascaded eight-input interrupt controllers. Each request input has its own 8-bit steering register. The registers sit at four consecutive addresses of a small register-write port. A steering value below sixteen names the target line. A value of sixteen or more switches that input off.

Internally the block keeps one level bit per pairing of a line and a request input. That makes 64 bits, and the bit for a pair sits at index `line*4 + input`. Several request inputs may therefore share a line. A line is high while any request input steered onto it is high. When a request input changes, only the bit for that input's current line is touched. When any steering register is written, every bit is rebuilt from the live request inputs and all sixteen lines are refreshed. The block also reports, for each request input, whether its route is on and which line it drives.

Top module: `pirq_router`

## Requirements
- R1: After reset, every steering register reads back as 0x80. All route-enable outputs are 0 and all sixteen line outputs are low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register at `cfg_addr`, where address 0 through 3 selects request input 0 through 3. `cfg_rdata` returns, combinationally, the stored value at `cfg_addr`. Stored values of 16 or more read back unchanged.
- R3: When a steering value v is below 16, `route_en[p]` is 1 and `route_line[4p+3:4p]` equals v. Request input p is then steered to line v.
- R4: When a steering value is 16 or more, `route_en[p]` is 0. Toggling that request input has no effect on any line output.
- R5: Each line output is high exactly when at least one enabled request input steered to that line is high. Several inputs may share one line.
- R6: A change on a request input shows on the line outputs after exactly one rising clock edge, and not before it.
- R7: After any steering write, all sixteen lines reflect the live request inputs under the new steering on the next edge. A line a held-high input has moved away from goes low, and its new line goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Steering register write strobe |
| cfg_addr | input | 2 | Register select for write and readback |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Readback of the register at `cfg_addr` |
| pirq_in | input | 4 | Request inputs, active high |
| line_out | output | 16 | Legacy interrupt line levels |
| route_en | output | 4 | Per-input route enabled |
| route_line | output | 16 | Per-input selected line, 4 bits per input |

## Verification
A stale or misplaced level bit is visible at the ports. It keeps a line high after every enabled input steered there has dropped, or it raises a line nothing is steered to. Either error appears on the edge right after the faulty update. A missed rebuild after a write leaves the old line high and the new one low from the next edge onward. A disabled input that leaks shows as a line change one edge after it toggles. Steering register faults appear at once on the readback and route-report outputs.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NPIRQ = 4,
  parameter int NLINE = 16,
  parameter int RW = 8,
  parameter logic [RW-1:0] RST_ROUTE = 8'h80,
  localparam int AW = $clog2(NPIRQ),
  localparam int LW = $clog2(NLINE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [RW-1:0]       cfg_wdata,
  output logic [RW-1:0]       cfg_rdata,
  input  logic [NPIRQ-1:0]    pirq_in,
  output logic [NLINE-1:0]    line_out,
  output logic [NPIRQ-1:0]    route_en,
  output logic [NPIRQ*LW-1:0] route_line
);

  localparam int NBITS = NPIRQ * NLINE;

  logic [RW-1:0]    route_q  [NPIRQ];
  logic [RW-1:0]    route_nx [NPIRQ];
  logic [NPIRQ-1:0] pirq_q;
  logic [NBITS-1:0] lvl_q, lvl_d;

  always_comb begin
    for (int p = 0; p < NPIRQ; p++) route_nx[p] = route_q[p];
    if (cfg_we && int'(cfg_addr) < NPIRQ) route_nx[cfg_addr] = cfg_wdata;
  end

  always_comb begin
    lvl_d = lvl_q;
    if (cfg_we) begin
      for (int l = 0; l < NLINE; l++)
        for (int p = 0; p < NPIRQ; p++)
          lvl_d[l*NPIRQ+p] = pirq_in[p] && (route_nx[p] == RW'(l));
    end else begin
      for (int p = 0; p < NPIRQ; p++)
        if (pirq_in[p] != pirq_q[p] && route_q[p] < RW'(NLINE))
          lvl_d[int'(route_q[p][LW-1:0])*NPIRQ + p] = pirq_in[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIRQ; p++) route_q[p] <= RST_ROUTE;
      pirq_q <= '0;
      lvl_q  <= '0;
    end else begin
      for (int p = 0; p < NPIRQ; p++) route_q[p] <= route_nx[p];
      pirq_q <= pirq_in;
      lvl_q  <= lvl_d;
    end
  end

  assign cfg_rdata = route_q[cfg_addr];

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    assign line_out[l] = |lvl_q[l*NPIRQ +: NPIRQ];
  end

  for (genvar p = 0; p < NPIRQ; p++) begin : g_rep
    assign route_en[p] = route_q[p] < RW'(NLINE);
    assign route_line[p*LW +: LW] = route_q[p][LW-1:0];
  end

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NPIRQ = 4,
  parameter int NLINE = 16,
  parameter int RW = 8,
  localparam int AW = $clog2(NPIRQ),
  localparam int LW = $clog2(NLINE)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [AW-1:0]       cfg_addr,
  input logic [RW-1:0]       cfg_wdata,
  input logic [RW-1:0]       cfg_rdata,
  input logic [NPIRQ-1:0]    pirq_in,
  input logic [NLINE-1:0]    line_out,
  input logic [NPIRQ-1:0]    route_en,
  input logic [NPIRQ*LW-1:0] route_line
);

  logic [NPIRQ-1:0] pirq_d;
  logic             we_d;
  logic [AW-1:0]    addr_d;
  logic [RW-1:0]    wdata_d;
  logic [NLINE-1:0] exp_lines;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pirq_d <= '0; we_d <= 1'b0; addr_d <= '0; wdata_d <= '0;
    end else begin
      pirq_d <= pirq_in; we_d <= cfg_we; addr_d <= cfg_addr; wdata_d <= cfg_wdata;
    end
  end

  always_comb begin
    exp_lines = '0;
    for (int p = 0; p < NPIRQ; p++)
      if (pirq_d[p] && route_en[p]) exp_lines[route_line[p*LW +: LW]] = 1'b1;
  end

  // R5, R6, R7
  a_r5_line_levels: assert property (@(posedge clk) disable iff (!rst_n)
    line_out == exp_lines);

  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (route_en == '0) |-> (line_out == '0));

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (we_d && cfg_addr == addr_d) |-> (cfg_rdata == wdata_d));

  a_r3_route_report: assert property (@(posedge clk) disable iff (!rst_n)
    we_d |-> (route_en[addr_d] == (wdata_d < RW'(NLINE))));

endmodule

bind pirq_router pirq_router_chk #(.NPIRQ(NPIRQ), .NLINE(NLINE), .RW(RW)) u_chk (.*);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pirq_in = '0;
  logic [15:0] line_out;
  logic [3:0]  route_en;
  logic [15:0] route_line;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_route [4];
  logic [3:0] m_pirq;

  always #2 clk = ~clk;

  pirq_router dut (.*);

  function automatic logic [15:0] exp_lines();
    logic [15:0] e = '0;
    for (int p = 0; p < 4; p++)
      if (m_pirq[p] && m_route[p] < 8'd16) e[m_route[p][3:0]] = 1'b1;
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [3:0]  en;
    logic [15:0] ln;
    for (int p = 0; p < 4; p++) begin
      en[p] = m_route[p] < 8'd16;
      ln[p*4 +: 4] = m_route[p][3:0];
    end
    chk({tag, " R5 lines"}, 32'(line_out), 32'(exp_lines()));
    chk({tag, " R3 route_en"}, 32'(route_en), 32'(en));
    chk({tag, " R3 route_line"}, 32'(route_line), 32'(ln));
    chk({tag, " R2 readback"}, 32'(cfg_rdata), 32'(m_route[cfg_addr]));
  endtask

  task automatic step(bit we, logic [1:0] a, logic [7:0] d, logic [3:0] p, string tag);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; pirq_in = p;
    if (we) m_route[a] = d;
    m_pirq = p;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 4; p++) m_route[p] = 8'h80;
    m_pirq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lines low", 32'(line_out), 0);
    chk("R1 route_en", 32'(route_en), 0);
    for (int a = 0; a < 4; a++) begin
      cfg_addr = 2'(a); #0.5;
      chk("R1 readback 0x80", 32'(cfg_rdata), 32'h80);
    end

    // R4: all disabled, inputs toggle, lines stay low
    step(0, 0, 0, 4'hF, "R4 disabled high");
    step(0, 0, 0, 4'h0, "R4 disabled low");
    // R7/R3: steer A to 3 while A high
    step(0, 0, 0, 4'h1, "R4 pre");
    step(1, 0, 8'd3, 4'h1, "R7 A->3");
    // R5 sharing
    step(1, 1, 8'd3, 4'h3, "R5 B->3");
    step(0, 1, 0, 4'h2, "R5 A drop shared");
    step(0, 1, 0, 4'h0, "R5 both low");
    // R6 latency: change not visible before the edge
    cfg_we = 0; pirq_in = 4'h1; m_pirq = 4'h1;
    #0.5;
    chk("R6 no early change", 32'(line_out), 0);
    @(negedge clk);
    check_all("R6 after one edge");
    // R7 move held-high input
    step(1, 0, 8'd9, 4'h1, "R7 A 3->9");
    chk("R7 line3 low", 32'(line_out[3]), 0);
    chk("R7 line9 high", 32'(line_out[9]), 1);
    // R4 disable while high, toggle ignored, R2 readback of disable value
    step(1, 0, 8'd16, 4'h1, "R4 A off");
    step(0, 0, 0, 4'h0, "R4 A toggle low");
    step(0, 0, 0, 4'h1, "R4 A toggle high");
    chk("R2 readback 16", 32'(cfg_rdata), 32'd16);
    step(1, 2, 8'd15, 4'h5, "R3 C->15");
    step(1, 3, 8'hFF, 4'hD, "R4 D 0xFF");

    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom % 4) == 0;
      logic [1:0] a = 2'($urandom);
      logic [7:0] d = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 16);
      logic [3:0] p = ($urandom % 2) ? 4'($urandom) : m_pirq;
      step(we, a, d, p, "RND R5 R6 R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule